// File: doc/BRIEF.md
# Per-Character Blink Timer

This block produces the foreground enable for on-screen characters that blink. It counts field (vertical) pulses in a free-running counter and turns that count into a square-ish blink waveform whose period and on/off ratio are chosen by a 3-bit control field. The waveform is then combined with the blink attribute bit fetched from the display memory word of the character being drawn. The result decides whether that character's foreground pixels are shown or suppressed.

The control field comes from a display control register that is cleared by reset, so after reset no character blinks until software selects a duty. The counter is never reloaded except by reset. All characters that blink therefore blink in phase with one another.

Top module: `osd_blink_timer`

## Requirements
- R1: Reset clears the field counter to zero. Right after reset, a character with its attribute set and a non-zero duty selected is hidden, because count 0 lies in the hidden part of every period.
- R2: The field counter advances by exactly one for each clock cycle in which `field_pulse` is high. It holds its value when `field_pulse` is low, and wraps to zero after 2**CNT_W fields (64 by default).
- R3: Bit 2 of `blink_ctrl` selects the period. A value of 1 gives the long period of 2**CNT_W fields (64), with the phase equal to the full count. A value of 0 gives the short period of half that (32), with the phase equal to the count modulo 32.
- R4: Duty code `blink_ctrl[1:0]` = 00 disables blinking: `char_en` stays 1 for every count.
- R5: Duty code 01 hides an attributed character while the phase is below one quarter of the selected period (16 fields long, 8 fields short).
- R6: Duty code 10 hides an attributed character while the phase is below one half of the period (32 long, 16 short).
- R7: Duty code 11 hides an attributed character while the phase is below three quarters of the period (48 long, 24 short). At every other phase it is shown.
- R8: When `char_blink_attr` is 0, `char_en` is 1 whatever the counter and control field hold. With the default REG_OUT = 0, `char_en` follows `char_blink_attr` and `blink_ctrl` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_pulse | input | 1 | One-cycle strobe per video field |
| blink_ctrl | input | 3 | Bit 2: period select (1 = long); bits 1:0: duty code |
| char_blink_attr | input | 1 | Blink attribute bit of the current character |
| char_en | output | 1 | 1 = draw the character foreground, 0 = suppress it |

## Verification
The checker watches four things on every cycle: the counter steps by one on each field pulse and holds otherwise, an unattributed or duty-off character is never suppressed, and the long-period quarter and three-quarter boundaries are honoured. The exact hide window for each of the eight period/duty combinations, the short-period phase folding, and the wrap after 64 fields can only be shown by the bench. The bench does this by walking the counter through more than a full period and comparing every combination against a model of the expected enable at each count.

// File: rtl/osd_blink_pkg.sv
package osd_blink_pkg;

   typedef enum logic [1:0] {
      DUTY_OFF  = 2'b00,
      DUTY_Q1   = 2'b01,
      DUTY_HALF = 2'b10,
      DUTY_Q3   = 2'b11
   } duty_e;

   typedef struct packed {
      logic  long_period;
      duty_e duty;
   } blink_ctrl_t;

   localparam int CTRL_W = $bits(blink_ctrl_t);

endpackage

// File: rtl/osd_blink_field_ctr.sv
module osd_blink_field_ctr #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_pulse,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (field_pulse) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/osd_blink_wave.sv
module osd_blink_wave
   import osd_blink_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] cnt,
   input  blink_ctrl_t      ctrl,
   output logic             hide_phase
);

   localparam int LONG_SHIFT  = CNT_W - 2;
   localparam int SHORT_SHIFT = CNT_W - 3;

   generate
      if (CNT_W < 3) begin : g_bad_width
         $error("osd_blink_wave: CNT_W must be at least 3");
      end
   endgenerate

   logic [CNT_W:0] phase;
   logic [CNT_W:0] duty_x;
   logic [CNT_W:0] thresh;

   always_comb begin
      duty_x = {{(CNT_W-1){1'b0}}, ctrl.duty};
      if (ctrl.long_period) begin
         phase  = {1'b0, cnt};
         thresh = duty_x << LONG_SHIFT;
      end else begin
         phase  = {2'b00, cnt[CNT_W-2:0]};
         thresh = duty_x << SHORT_SHIFT;
      end
      hide_phase = (phase < thresh);
   end

endmodule

// File: rtl/osd_blink_gate.sv
module osd_blink_gate #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hide_phase,
   input  logic attr,
   output logic char_en
);

   logic en_next;
   assign en_next = ~(attr & hide_phase);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) char_en <= 1'b1;
            else        char_en <= en_next;
         end
      end else begin : g_comb
         assign char_en = en_next;
      end
   endgenerate

endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer
   import osd_blink_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       field_pulse,
   input  logic [2:0] blink_ctrl,
   input  logic       char_blink_attr,
   output logic       char_en
);

   generate
      if (CTRL_W != 3) begin : g_bad_ctrl
         $error("osd_blink_timer: control struct must be 3 bits");
      end
   endgenerate

   logic [CNT_W-1:0] field_cnt;
   blink_ctrl_t      ctrl_s;
   logic             hide_phase;

   assign ctrl_s.long_period = blink_ctrl[2];
   assign ctrl_s.duty        = duty_e'(blink_ctrl[1:0]);

   osd_blink_field_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_pulse (field_pulse),
      .cnt         (field_cnt)
   );

   osd_blink_wave #(.CNT_W(CNT_W)) u_wave (
      .cnt        (field_cnt),
      .ctrl       (ctrl_s),
      .hide_phase (hide_phase)
   );

   osd_blink_gate #(.REG_OUT(REG_OUT)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .hide_phase (hide_phase),
      .attr       (char_blink_attr),
      .char_en    (char_en)
   );

endmodule

// File: rtl/osd_blink_checker.sv
module osd_blink_checker #(
   parameter int CNT_W   = 6,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             field_pulse,
   input logic [2:0]       blink_ctrl,
   input logic             char_blink_attr,
   input logic             char_en,
   input logic [CNT_W-1:0] field_cnt
);

   localparam int LONG_P = 1 << CNT_W;
   localparam int Q1_LIM = LONG_P / 4;
   localparam int Q3_LIM = (3 * LONG_P) / 4;

   // R2: one step per field pulse
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      field_pulse |=> (field_cnt == $past(field_cnt) + 1'b1));

   // R2: hold without a pulse
   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !field_pulse |=> $stable(field_cnt));

   generate
      if (!REG_OUT) begin : g_comb_chk
         // R8: unattributed characters are always drawn
         a_r8_attr_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !char_blink_attr |-> char_en);

         // R4: duty off never hides
         a_r4_duty_off: assert property (@(posedge clk) disable iff (!rst_n)
            (blink_ctrl[1:0] == 2'b00) |-> char_en);

         // R5: long period, quarter duty, first quarter hidden
         a_r5_long_quarter: assert property (@(posedge clk) disable iff (!rst_n)
            (blink_ctrl == 3'b101 && char_blink_attr && int'(field_cnt) < Q1_LIM)
            |-> !char_en);

         // R7: long period, three-quarter duty, last quarter shown
         a_r7_long_tail: assert property (@(posedge clk) disable iff (!rst_n)
            (blink_ctrl == 3'b111 && int'(field_cnt) >= Q3_LIM) |-> char_en);
      end
   endgenerate

endmodule

bind osd_blink_timer osd_blink_checker #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .field_pulse     (field_pulse),
   .blink_ctrl      (blink_ctrl),
   .char_blink_attr (char_blink_attr),
   .char_en         (char_en),
   .field_cnt       (field_cnt)
);

// File: tb/tb_osd_blink_timer.sv
`timescale 1ns/1ps
module tb_osd_blink_timer;

   localparam int CW     = 6;
   localparam int LONG_P = 1 << CW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       field_pulse = 1'b0;
   logic [2:0] blink_ctrl = 3'b000;
   logic       char_blink_attr = 1'b0;
   logic       char_en;

   int checks = 0;
   int errors = 0;
   int mcnt   = 0;

   always #2 clk = ~clk;

   osd_blink_timer #(.CNT_W(CW), .REG_OUT(1'b0)) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .field_pulse     (field_pulse),
      .blink_ctrl      (blink_ctrl),
      .char_blink_attr (char_blink_attr),
      .char_en         (char_en)
   );

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: char_en=%0b expected %0b (count=%0d ctrl=%03b attr=%0b)",
                  req, act, exp, mcnt % LONG_P, blink_ctrl, char_blink_attr);
      end
   endtask

   // Sweeps every period/duty/attribute combination at the current count.
   task automatic check_all(input string ctx);
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < 4; d++) begin
            for (int a = 0; a < 2; a++) begin
               int    per, ph, thr;
               logic  exp_en;
               string req;
               blink_ctrl      = {p[0], d[1:0]};
               char_blink_attr = a[0];
               #1;
               per    = (p == 1) ? LONG_P : LONG_P / 2;
               ph     = mcnt % per;
               thr    = d * per / 4;
               exp_en = !((a == 1) && (ph < thr));
               if (a == 0)      req = "R8";
               else if (d == 0) req = "R4";
               else if (d == 1) req = "R5";
               else if (d == 2) req = "R6";
               else             req = "R7";
               if (p == 0 && a == 1 && d != 0) req = {req, "/R3"};
               check_bit({ctx, " ", req}, char_en, exp_en);
            end
         end
      end
   endtask

   task automatic pulse_field();
      @(negedge clk);
      field_pulse = 1'b1;
      @(negedge clk);
      field_pulse = 1'b0;
      mcnt++;
   endtask

   task automatic t_reset();
      blink_ctrl      = 3'b000;
      char_blink_attr = 1'b1;
      #1;
      check_bit("R1/R4 reset duty off", char_en, 1'b1);
      blink_ctrl = 3'b110;
      #1;
      check_bit("R1 reset count zero hidden", char_en, 1'b0);
      check_all("R1");
   endtask

   task automatic t_sweep(input int n);
      for (int i = 0; i < n; i++) begin
         pulse_field();
         check_all("R2 sweep");
      end
   endtask

   task automatic t_hold();
      field_pulse = 1'b0;
      repeat (40) @(negedge clk);
      check_all("R2 hold");
   endtask

   task automatic t_burst();
      @(negedge clk);
      field_pulse = 1'b1;
      repeat (5) @(negedge clk);
      field_pulse = 1'b0;
      mcnt += 5;
      check_all("R2 burst");
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sweep(LONG_P + 6);
      t_hold();
      t_burst();
      t_sweep(20);
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule